// File: doc/BRIEF.md
# Seeded Random Generator Controller

The block is the control side of a stand-alone random number generator. Software talks to it through a small register window: a command register that takes a no-op, a generate request or a reseed request, a status word that shows whether the generator has been seeded and whether it is busy generating or reseeding, a width selector, an interrupt enable word, a write-one-to-clear interrupt status word, eight 32-bit result words, an auto-reseed limit and a constant identification word.

The entropy and conditioning core is modelled as a start/done engine that answers every start with a done pulse a fixed `LATENCY` cycles later. When a generation finishes, the controller fills the result words from a 32-bit noise input, counts the work done in units of 16 bytes, and starts a fresh seed on its own once the programmed limit is reached. After reset the controller seeds itself before it accepts work. Commands that arrive while the engine is busy are held and run when it becomes free.

Top module: `rng_ctrl`

## Requirements
- R1: During reset and right after it, status (0x04) reads 0x8000_0000 (bit 31 = reseeding). Reseeding lasts exactly LATENCY+1 cycles after reset is released. Status then reads 0x0000_0200 (bit 9 = seeded), and bit 9 never clears again.
- R2: Offset 0xF0 reads 0x0000_46BC. An unmapped offset reads 0, and a write to it has no effect.
- R3: Writing 1 to the command register (0x00) while idle sets status bit 30 (generating) for exactly LATENCY+1 cycles, starting with the cycle after the write. Generation then sets interrupt status (0x14) bit 0 (ready).
- R4: When generation completes, result word k (offset 0x20+4k) takes the noise input rotated left by 4*k bits, with the noise sampled in the completing cycle.
- R5: Mode register (0x08) bit 3 selects 256-bit output when 1, and reads back with all other bits 0. With bit 3 = 0 only words 0 to 3 are written, and words 4 to 7 keep their earlier values.
- R6: In interrupt status, bit 0 (ready) and bit 1 (seed done) are cleared by writing 1 to them. Writing 0 leaves them unchanged. Every completed seed, including the one after reset, sets bit 1.
- R7: Writing 2 to the command register while idle sets status bit 31 for LATENCY+1 cycles, with bit 9 held at 1 throughout. It also clears the auto-reseed request count.
- R8: A generate command that arrives while a reseed is running is held. It starts in the cycle after the reseed completes and runs for LATENCY+1 cycles.
- R9: Each generation adds 1 (128-bit) or 2 (256-bit) to a request count. If the limit at 0x60 is nonzero and the new count reaches it, a reseed starts in the cycle after the generation completes. A limit of 0 never triggers a reseed.
- R10: The interrupt output is 1 exactly when enable bit 31 is set and a pending status bit has its enable set: bit 0 for ready, bit 1 for seed done. The enable register reads back only bits 31, 1 and 0.
- R11: Command values 0 and 3 leave status, interrupt status and the result words unchanged.
- R12: Status bits 30 and 31 are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| noise_i | input | 32 | Raw entropy word from the noise source |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with LATENCY = 4 and CNT_W = 4. The short latency lets it count every busy window cycle by cycle and compare it with LATENCY+1. The narrow counter lets it sweep the auto-reseed limit over 1, 2 and 3, with both step sizes, and check that the reseed comes exactly on the request that reaches the limit. Both output widths are crossed with several noise patterns. This shows that words 4 to 7 keep their values across a 128-bit generation and that every word has its own rotation.

// File: rtl/rng_pkg.sv
package rng_pkg;

    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 8;
    localparam int NUM_WORDS = 8;
    localparam int ROT_STEP  = 4;

    localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ISTAT = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_LIMIT = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_ID    = 8'hF0;
    localparam logic [2:0]        WORD_PAGE = 3'b001;

    localparam logic [BUS_W-1:0] ID_VALUE = 32'h0000_46BC;
    localparam logic [BUS_W-1:0] CMD_RAND = 32'd1;
    localparam logic [BUS_W-1:0] CMD_SEED = 32'd2;

    localparam int STAT_SEEDED_BIT = 9;
    localparam int STAT_GEN_BIT    = 30;
    localparam int STAT_RESEED_BIT = 31;
    localparam int MODE_WIDE_BIT   = 3;
    localparam int IEN_GLB_BIT     = 31;
    localparam int IEN_SEED_BIT    = 1;
    localparam int IEN_RDY_BIT     = 0;
    localparam int IST_RDY_BIT     = 0;
    localparam int IST_SEED_BIT    = 1;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_GEN  = 2'd1,
        SQ_SEED = 2'd2
    } seq_state_e;

    function automatic logic [BUS_W-1:0] rot_nibbles(input logic [BUS_W-1:0] x,
                                                     input int k);
        logic [2*BUS_W-1:0] dbl;
        dbl = {x, x} << (ROT_STEP * k);
        return dbl[2*BUS_W-1:BUS_W];
    endfunction

endpackage

// File: rtl/rng_core_stub.sv
module rng_core_stub #(
    parameter int LATENCY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = $clog2(LATENCY + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } stub_t;

    stub_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.cnt = CW'(LATENCY);
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o = (s_q.cnt == CW'(1));

endmodule

// File: rtl/rng_seq.sv
module rng_seq
    import rng_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rand_req_i,
    input  logic             seed_req_i,
    input  logic             wide_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             core_done_i,
    output logic             core_start_o,
    output logic             seeded_o,
    output logic             gen_o,
    output logic             reseed_o,
    output logic             gen_done_o,
    output logic             gen_wide_o,
    output logic             seed_done_o
);
    localparam int SUM_W = CNT_W + 1;

    typedef struct packed {
        seq_state_e       state;
        logic             start;
        logic             seeded;
        logic             pend_rand;
        logic             pend_seed;
        logic             wide;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t q_d, q_q;
    logic want_rand, want_seed;
    logic [SUM_W-1:0] sum;
    logic limit_hit;

    always_comb begin
        q_d         = q_q;
        q_d.start   = 1'b0;
        gen_done_o  = 1'b0;
        seed_done_o = 1'b0;
        want_rand   = q_q.pend_rand | rand_req_i;
        want_seed   = q_q.pend_seed | seed_req_i;
        q_d.pend_rand = want_rand;
        q_d.pend_seed = want_seed;
        sum       = SUM_W'(q_q.cnt) + SUM_W'(q_q.wide ? 2 : 1);
        limit_hit = (limit_i != '0) && (sum >= SUM_W'(limit_i));

        unique case (q_q.state)
            SQ_IDLE: begin
                if (want_seed) begin
                    q_d.state     = SQ_SEED;
                    q_d.start     = 1'b1;
                    q_d.pend_seed = 1'b0;
                    q_d.cnt       = '0;
                end else if (want_rand) begin
                    q_d.state     = SQ_GEN;
                    q_d.start     = 1'b1;
                    q_d.pend_rand = 1'b0;
                    q_d.wide      = wide_i;
                end
            end
            SQ_GEN: begin
                if (core_done_i) begin
                    gen_done_o = 1'b1;
                    if (limit_hit || want_seed) begin
                        q_d.state     = SQ_SEED;
                        q_d.start     = 1'b1;
                        q_d.pend_seed = 1'b0;
                        q_d.cnt       = '0;
                    end else begin
                        q_d.cnt = sum[CNT_W-1:0];
                        if (want_rand) begin
                            q_d.state     = SQ_GEN;
                            q_d.start     = 1'b1;
                            q_d.pend_rand = 1'b0;
                            q_d.wide      = wide_i;
                        end else begin
                            q_d.state = SQ_IDLE;
                        end
                    end
                end
            end
            SQ_SEED: begin
                if (core_done_i) begin
                    seed_done_o = 1'b1;
                    q_d.seeded  = 1'b1;
                    if (want_seed) begin
                        q_d.state     = SQ_SEED;
                        q_d.start     = 1'b1;
                        q_d.pend_seed = 1'b0;
                        q_d.cnt       = '0;
                    end else if (want_rand) begin
                        q_d.state     = SQ_GEN;
                        q_d.start     = 1'b1;
                        q_d.pend_rand = 1'b0;
                        q_d.wide      = wide_i;
                    end else begin
                        q_d.state = SQ_IDLE;
                    end
                end
            end
            default: q_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q       <= '0;
            q_q.state <= SQ_SEED;
            q_q.start <= 1'b1;
        end else begin
            q_q <= q_d;
        end
    end

    assign core_start_o = q_q.start;
    assign seeded_o     = q_q.seeded;
    assign gen_o        = (q_q.state == SQ_GEN);
    assign reseed_o     = (q_q.state == SQ_SEED);
    assign gen_wide_o   = q_q.wide;

endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
    import rng_pkg::*;
#(
    parameter int LATENCY = 16,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [BUS_W-1:0]  noise_i,
    output logic              irq_o
);
    localparam int HALF = NUM_WORDS / 2;
    localparam int IDX_W = $clog2(NUM_WORDS);

    typedef struct packed {
        logic                              wide;
        logic                              ien_glb;
        logic                              ien_seed;
        logic                              ien_rdy;
        logic                              rdy;
        logic                              seed_flag;
        logic [CNT_W-1:0]                  limit;
        logic [NUM_WORDS-1:0][BUS_W-1:0]   words;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_cmd, rand_req, seed_req, wr_istat;
    logic core_start, core_done;
    logic seq_seeded, seq_gen, seq_reseed;
    logic gen_done, gen_wide, seed_done;
    logic rdy_flag, ien_glb;

    assign wr_cmd   = bus_wr && (bus_addr == OFS_CMD);
    assign rand_req = wr_cmd && (bus_wdata == CMD_RAND);
    assign seed_req = wr_cmd && (bus_wdata == CMD_SEED);
    assign wr_istat = bus_wr && (bus_addr == OFS_ISTAT);

    rng_seq #(
        .CNT_W(CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rand_req_i  (rand_req),
        .seed_req_i  (seed_req),
        .wide_i      (r_q.wide),
        .limit_i     (r_q.limit),
        .core_done_i (core_done),
        .core_start_o(core_start),
        .seeded_o    (seq_seeded),
        .gen_o       (seq_gen),
        .reseed_o    (seq_reseed),
        .gen_done_o  (gen_done),
        .gen_wide_o  (gen_wide),
        .seed_done_o (seed_done)
    );

    rng_core_stub #(
        .LATENCY(LATENCY)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(core_start),
        .done_o (core_done)
    );

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            unique case (bus_addr)
                OFS_MODE:  r_d.wide = bus_wdata[MODE_WIDE_BIT];
                OFS_IEN: begin
                    r_d.ien_glb  = bus_wdata[IEN_GLB_BIT];
                    r_d.ien_seed = bus_wdata[IEN_SEED_BIT];
                    r_d.ien_rdy  = bus_wdata[IEN_RDY_BIT];
                end
                OFS_LIMIT: r_d.limit = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        r_d.rdy       = (r_q.rdy & ~(wr_istat & bus_wdata[IST_RDY_BIT])) | gen_done;
        r_d.seed_flag = (r_q.seed_flag & ~(wr_istat & bus_wdata[IST_SEED_BIT])) | seed_done;
        if (gen_done) begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (k < HALF || gen_wide) begin
                    r_d.words[k] = rot_nibbles(noise_i, k);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1:5] == WORD_PAGE && bus_addr[1:0] == 2'b00) begin
            bus_rdata = r_q.words[bus_addr[IDX_W+1:2]];
        end else begin
            unique case (bus_addr)
                OFS_STAT: begin
                    bus_rdata[STAT_SEEDED_BIT] = seq_seeded;
                    bus_rdata[STAT_GEN_BIT]    = seq_gen;
                    bus_rdata[STAT_RESEED_BIT] = seq_reseed;
                end
                OFS_MODE:  bus_rdata[MODE_WIDE_BIT] = r_q.wide;
                OFS_IEN: begin
                    bus_rdata[IEN_GLB_BIT]  = r_q.ien_glb;
                    bus_rdata[IEN_SEED_BIT] = r_q.ien_seed;
                    bus_rdata[IEN_RDY_BIT]  = r_q.ien_rdy;
                end
                OFS_ISTAT: begin
                    bus_rdata[IST_RDY_BIT]  = r_q.rdy;
                    bus_rdata[IST_SEED_BIT] = r_q.seed_flag;
                end
                OFS_LIMIT: bus_rdata = BUS_W'(r_q.limit);
                OFS_ID:    bus_rdata = ID_VALUE;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign rdy_flag = r_q.rdy;
    assign ien_glb  = r_q.ien_glb;
    assign irq_o    = r_q.ien_glb & ((r_q.rdy & r_q.ien_rdy) | (r_q.seed_flag & r_q.ien_seed));

endmodule

// File: rtl/rng_ctrl_chk.sv
module rng_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        gen,
    input logic        reseed,
    input logic        seeded,
    input logic        core_start,
    input logic        core_done,
    input logic        rdy,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        ien_glb,
    input logic        irq
);
    p_busy_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen && reseed));

    p_seeded_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seeded |=> seeded);

    p_done_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> (gen || reseed));

    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    p_rdy_after_gen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(gen));

    p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h14 && bus_wdata[0] && !gen) |=> !rdy);

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_glb |-> !irq);

endmodule

bind rng_ctrl rng_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen       (seq_gen),
    .reseed    (seq_reseed),
    .seeded    (seq_seeded),
    .core_start(core_start),
    .core_done (core_done),
    .rdy       (rdy_flag),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ien_glb   (ien_glb),
    .irq       (irq_o)
);

// File: tb/tb_rng_ctrl.sv
module tb_rng_ctrl;
    localparam int LAT   = 4;
    localparam int CNT_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] noise_i = '0;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    logic [31:0] exp_w [8];

    rng_ctrl #(.LATENCY(LAT), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .noise_i(noise_i), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic count_bit(input int bitpos, output int n);
        logic [31:0] s;
        n = 0;
        for (int g = 0; g < 200; g++) begin
            rd(8'h04, s);
            if (s[30] && s[31]) chk(1'b0, "R12 both busy bits", s, 32'h0);
            if (!s[bitpos]) break;
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] rotw(input logic [31:0] x, input int k);
        return (x << (4 * k)) | (x >> (32 - 4 * k));
    endfunction

    task automatic check_words(input string tag);
        logic [31:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(8'h20 + 8'(4 * k), v);
            chk(v == exp_w[k], tag, v, exp_w[k]);
        end
    endtask

    task automatic do_gen(input logic wide, input logic [31:0] nz, output int n);
        noise_i = nz;
        wr(8'h00, 32'd1);
        count_bit(30, n);
        for (int k = 0; k < 8; k++) if (k < 4 || wide) exp_w[k] = rotw(nz, k);
    endtask

    task automatic wait_seed_done;
        int n;
        count_bit(31, n);
    endtask

    task automatic print_summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        print_summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        for (int k = 0; k < 8; k++) exp_w[k] = '0;

        repeat (4) @(negedge clk);
        rd(8'h04, v);
        chk(v == 32'h8000_0000, "R1 status in reset", v, 32'h8000_0000);
        @(negedge clk);
        rst_n = 1'b1;
        count_bit(31, n);
        chk(n == LAT + 1, "R1 initial seed length", n, LAT + 1);
        rd(8'h04, v);
        chk(v == 32'h0000_0200, "R1 seeded idle", v, 32'h200);
        rd(8'h14, v);
        chk(v == 32'h2, "R6 seed-done flag", v, 32'h2);
        wr(8'h14, 32'h0);
        rd(8'h14, v);
        chk(v == 32'h2, "R6 write 0 keeps flag", v, 32'h2);
        wr(8'h14, 32'h2);
        rd(8'h14, v);
        chk(v == 32'h0, "R6 write 1 clears seed flag", v, 32'h0);

        rd(8'hF0, v);
        chk(v == 32'h46BC, "R2 id word", v, 32'h46BC);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, v);
        chk(v == 32'h0, "R2 unmapped read", v, 32'h0);
        check_words("R2 unmapped write no effect on words");

        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v);
        chk(v == 32'h8, "R5 mode readback", v, 32'h8);

        for (int m = 1; m >= 0; m--) begin
            wr(8'h08, m[0] ? 32'h8 : 32'h0);
            for (int p = 0; p < 4; p++) begin
                logic [31:0] nz;
                nz = 32'h1357_9BDF ^ (32'(p) * 32'h9E37_79B9) ^ 32'(m * 32'h0F0F_0000);
                do_gen(m[0], nz, n);
                chk(n == LAT + 1, "R3 generate length", n, LAT + 1);
                rd(8'h04, v);
                chk(v == 32'h200, "R9 limit 0 no reseed", v, 32'h200);
                rd(8'h14, v);
                chk(v == 32'h1, "R3 ready flag set", v, 32'h1);
                check_words(m[0] ? "R4 wide words" : "R5 narrow keeps upper words");
                wr(8'h14, 32'h0);
                rd(8'h14, v);
                chk(v == 32'h1, "R6 write 0 keeps ready", v, 32'h1);
                wr(8'h14, 32'h1);
                rd(8'h14, v);
                chk(v == 32'h0, "R6 write 1 clears ready", v, 32'h0);
            end
        end

        noise_i = 32'hDEAD_BEEF;
        wr(8'h00, 32'd0);
        rd(8'h04, v);
        chk(v == 32'h200, "R11 NOP status", v, 32'h200);
        wr(8'h00, 32'd3);
        rd(8'h04, v);
        chk(v == 32'h200, "R11 code 3 status", v, 32'h200);
        repeat (LAT + 3) @(negedge clk);
        rd(8'h14, v);
        chk(v == 32'h0, "R11 no flags", v, 32'h0);
        check_words("R11 words unchanged");

        wr(8'h00, 32'd2);
        rd(8'h04, v);
        chk(v == 32'h8000_0200, "R7 reseeding keeps seeded", v, 32'h8000_0200);
        count_bit(31, n);
        chk(n == LAT + 1, "R7 reseed length", n, LAT + 1);
        rd(8'h14, v);
        chk(v == 32'h2, "R7 seed-done flag", v, 32'h2);
        wr(8'h14, 32'h2);

        wr(8'h08, 32'h8);
        noise_i = 32'hA5C3_0F96;
        wr(8'h00, 32'd2);
        wr(8'h00, 32'd1);
        rd(8'h04, v);
        chk(v == 32'h8000_0200, "R8 still reseeding", v, 32'h8000_0200);
        wait_seed_done();
        rd(8'h04, v);
        chk(v == 32'h4000_0200, "R8 held generate starts", v, 32'h4000_0200);
        count_bit(30, n);
        chk(n == LAT + 1, "R8 held generate length", n, LAT + 1);
        for (int k = 0; k < 8; k++) exp_w[k] = rotw(32'hA5C3_0F96, k);
        check_words("R8 held generate words");
        wr(8'h14, 32'h3);

        for (int lim = 1; lim <= 3; lim++) begin
            wr(8'h08, 32'h0);
            wr(8'h00, 32'd2);
            wait_seed_done();
            wr(8'h60, 32'(lim));
            for (int i = 1; i <= lim; i++) begin
                do_gen(1'b0, 32'h0000_1111 * 32'(i), n);
                rd(8'h04, v);
                chk(v == ((i == lim) ? 32'h8000_0200 : 32'h200), "R9 narrow count reseed", v,
                    (i == lim) ? 32'h8000_0200 : 32'h200);
            end
            count_bit(31, n);
            chk(n == LAT + 1, "R9 auto reseed length", n, LAT + 1);
        end
        wr(8'h00, 32'd2);
        wait_seed_done();
        wr(8'h60, 32'd3);
        do_gen(1'b0, 32'h2468_ACE0, n);
        rd(8'h04, v);
        chk(v == 32'h200, "R9 count 1 of 3", v, 32'h200);
        wr(8'h08, 32'h8);
        do_gen(1'b1, 32'h1111_2222, n);
        rd(8'h04, v);
        chk(v == 32'h8000_0200, "R9 wide step reaches 3", v, 32'h8000_0200);
        wait_seed_done();
        check_words("R4 words before auto reseed");
        wr(8'h60, 32'd0);
        wr(8'h14, 32'h3);

        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v);
        chk(v == 32'h8000_0003, "R10 enable readback", v, 32'h8000_0003);
        chk(irq_o == 1'b0, "R10 nothing pending", irq_o, 0);
        do_gen(1'b1, 32'h0BAD_F00D, n);
        chk(irq_o == 1'b1, "R10 ready raises irq", irq_o, 1);
        wr(8'h10, 32'h0000_0001);
        chk(irq_o == 1'b0, "R10 global off", irq_o, 0);
        wr(8'h10, 32'h8000_0002);
        chk(irq_o == 1'b0, "R10 ready masked", irq_o, 0);
        wr(8'h14, 32'h1);
        wr(8'h00, 32'd2);
        wait_seed_done();
        chk(irq_o == 1'b1, "R10 seed done raises irq", irq_o, 1);
        wr(8'h14, 32'h2);
        chk(irq_o == 1'b0, "R10 cleared", irq_o, 0);

        print_summary();
        $finish;
    end
endmodule